// File: doc/BRIEF.md
# Temperature Measurement Sequencer

This block runs one complete temperature measurement on a single-drop 1-Wire bus. It does this by commanding a byte-level bus master. A pulse on `start` begins the sequence. The sequencer resets the bus, addresses the only device with skip-ROM, and starts a conversion. It then waits a conversion time set by parameters. After the wait it resets the bus again, re-addresses the device and requests the scratchpad. Last, it reads the nine scratchpad bytes.

Each bus operation is a one-cycle `opReq` with an operation kind and a data byte. The master answers with a one-cycle `opDone`. That answer carries the byte it read back and, for a reset, whether a device answered. The sequencer runs a reflected CRC-8 over the bytes as they arrive. When the check passes, it publishes the raw signed temperature in sixteenths of a degree Celsius. When the check fails, or when a reset finds no device, it raises an error flag instead. The result flags and the temperature value stay constant between completions.

Top module: `therm_seq`

## Requirements
- R1: After reset, `busy`, `done`, `tempOk`, `tempErr`, `noDevice`, `opReq` and `tempRaw` are all zero.
- R2: A `start` pulse while idle raises `busy` in the next cycle. The first request of the measurement is a bus reset. `busy` stays high until the measurement completes.
- R3: Operation kinds on `opKind` are 0 for bus reset, 1 for write byte (with `opData`) and 2 for read byte. A full measurement issues these operations in this order: reset, write 0xCC, write 0x44, reset, write 0xCC, write 0xBE, then nine reads.
- R4: The reset that follows the convert command (0x44) is requested exactly D+1 cycles after the cycle in which `opDone` completes the convert write. D is CLK_HZ/1000*CONV_MS.
- R5: `opReq` is high for exactly one cycle per operation. No new request is issued until `opDone` has answered the previous one.
- R6: The CRC is computed bit-serially, LSB first, starting from 0. For each bit, f = crc[0] XOR data bit; the CRC shifts right by one and is XORed with 0x8C when f is 1. The result is valid only if the CRC over all nine bytes is zero. Otherwise `tempErr`=1 and `tempOk`=0.
- R7: On a valid result, `tempOk`=1, `tempErr`=0, `noDevice`=0, and `tempRaw` equals {byte 1, byte 0} of the scratchpad.
- R8: If `opPresence` is 0 when either reset completes, no further request is issued. `busy` falls, and `tempErr`=1, `noDevice`=1, `tempOk`=0.
- R9: `tempRaw`, `tempOk`, `tempErr` and `noDevice` change only when a measurement completes. A failed measurement leaves `tempRaw` at its previous value.
- R10: A `start` pulse while `busy` is high is ignored. It adds no requests and does not restart the sequence.
- R11: `done` pulses for one cycle in the cycle after the final `opDone` of a measurement (the ninth read, or an unanswered reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (pulse) |
| opReq | output | 1 | One-cycle request to the bus master |
| opKind | output | 2 | 0 reset, 1 write byte, 2 read byte |
| opData | output | 8 | Byte to write |
| opDone | input | 1 | Master finished the pending operation |
| opRdData | input | 8 | Byte read by a read operation |
| opPresence | input | 1 | A device answered the reset |
| busy | output | 1 | A measurement is in progress |
| done | output | 1 | One-cycle completion pulse |
| tempOk | output | 1 | Last measurement produced a valid temperature |
| tempErr | output | 1 | Last measurement failed |
| noDevice | output | 1 | Last failure was a missing device |
| tempRaw | output | 16 | Signed temperature, 1/16 degree C per LSB |

## Verification
Several internal faults each have a visible symptom at the ports. A wrong step or read-count register shows up as a request of the wrong kind or byte, or as an extra or missing request. The scoreboard catches this at the first wrong request. A delay counter that is off by any amount moves the second reset request. The move is measured to the exact cycle. A corrupted CRC register or a swapped byte capture is seen only at completion, as a wrong flag or value on the `done` cycle. Flags that drift between completions are caught by holding checks after each run.

// File: rtl/therm_seq_pkg.sv
`timescale 1ns/1ps
package therm_seq_pkg;

  localparam int SPAD_BYTES = 9;
  localparam logic [7:0] CMD_SKIP = 8'hCC;
  localparam logic [7:0] CMD_CONV = 8'h44;
  localparam logic [7:0] CMD_RDSP = 8'hBE;
  localparam logic [7:0] CRC_POLY = 8'h8C;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } opKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_PEND,
    ST_DELAY
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       crcClr;
    logic       capture;
    logic [3:0] byteIdx;
    logic       finish;
    logic       abort;
  } dpStrobe_t;

  // one byte through the bit-serial reflected CRC-8, LSB first
  function automatic logic [7:0] crc8Byte(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] acc;
    logic fb;
    acc = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb  = acc[0] ^ dataIn[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction

endpackage

// File: rtl/therm_seq_ctrl.sv
`timescale 1ns/1ps
module therm_seq_ctrl
  import therm_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned CONV_MS = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opDone,
  input  logic       opPresence,
  output logic       opReq,
  output logic [1:0] opKind,
  output logic [7:0] opData,
  output logic       busy,
  output dpStrobe_t  strb
);

  localparam int unsigned DLY_CYC = (CLK_HZ / 1000) * CONV_MS;
  localparam int DLY_W = $clog2(DLY_CYC + 1);

  localparam logic [2:0] STP_RST1  = 3'd0;
  localparam logic [2:0] STP_SKIP1 = 3'd1;
  localparam logic [2:0] STP_CONV  = 3'd2;
  localparam logic [2:0] STP_RST2  = 3'd3;
  localparam logic [2:0] STP_SKIP2 = 3'd4;
  localparam logic [2:0] STP_RDSP  = 3'd5;
  localparam logic [2:0] STP_READ  = 3'd6;

  ctlState_e  st;
  logic [2:0] step;
  logic [3:0] rdCnt;
  logic [DLY_W-1:0] dlyCnt;
  opKind_e    kindNow;
  logic       atDone;
  logic       isRst;
  logic       lastRead;

  always_comb begin
    kindNow = OP_WRITE;
    opData  = 8'hFF;
    case (step)
      STP_RST1, STP_RST2:   kindNow = OP_RESET;
      STP_SKIP1, STP_SKIP2: opData  = CMD_SKIP;
      STP_CONV:             opData  = CMD_CONV;
      STP_RDSP:             opData  = CMD_RDSP;
      default:              kindNow = OP_READ;
    endcase
  end

  assign opKind   = kindNow;
  assign opReq    = (st == ST_ISSUE);
  assign busy     = (st != ST_IDLE);
  assign atDone   = (st == ST_PEND) && opDone;
  assign isRst    = (step == STP_RST1) || (step == STP_RST2);
  assign lastRead = (rdCnt == 4'(SPAD_BYTES - 1));

  always_comb begin
    strb         = '0;
    strb.abort   = atDone && isRst && !opPresence;
    strb.crcClr  = atDone && (step == STP_RDSP);
    strb.capture = atDone && (step == STP_READ);
    strb.byteIdx = rdCnt;
    strb.finish  = atDone && (step == STP_READ) && lastRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      step   <= STP_RST1;
      rdCnt  <= '0;
      dlyCnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_ISSUE;
            step <= STP_RST1;
          end
        end
        ST_ISSUE: st <= ST_PEND;
        ST_PEND: begin
          if (opDone) begin
            if (isRst && !opPresence) begin
              st <= ST_IDLE;
            end else if (step == STP_CONV) begin
              st     <= ST_DELAY;
              dlyCnt <= '0;
            end else if (step == STP_READ) begin
              if (lastRead) begin
                st <= ST_IDLE;
              end else begin
                rdCnt <= rdCnt + 4'd1;
                st    <= ST_ISSUE;
              end
            end else begin
              if (step == STP_RDSP) rdCnt <= '0;
              step <= step + 3'd1;
              st   <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (dlyCnt == DLY_W'(DLY_CYC - 1)) begin
            st   <= ST_ISSUE;
            step <= STP_RST2;
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    opReq |=> !opReq);

  // R2
  first_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (opReq && opKind == OP_RESET));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (!busy && !opReq));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !opDone) |=> busy);

endmodule

// File: rtl/therm_seq_dp.sv
`timescale 1ns/1ps
module therm_seq_dp
  import therm_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [7:0]  rdData,
  output logic [15:0] tempRaw,
  output logic        tempOk,
  output logic        tempErr,
  output logic        noDevice,
  output logic        done
);

  localparam int TEMP_BYTES = 2;

  logic [7:0] crcReg;
  logic [7:0] crcNow;
  logic [7:0] tByte [TEMP_BYTES];

  assign crcNow = crc8Byte(crcReg, rdData);

  generate
    for (genvar g = 0; g < TEMP_BYTES; g++) begin : g_tbyte
      always_ff @(posedge clk) begin
        if (!rstN) tByte[g] <= '0;
        else if (strb.capture && strb.byteIdx == 4'(g)) tByte[g] <= rdData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strb.crcClr) begin
      crcReg <= '0;
    end else if (strb.capture) begin
      crcReg <= crcNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempRaw  <= '0;
      tempOk   <= 1'b0;
      tempErr  <= 1'b0;
      noDevice <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.abort) begin
        done     <= 1'b1;
        tempOk   <= 1'b0;
        tempErr  <= 1'b1;
        noDevice <= 1'b1;
      end else if (strb.finish) begin
        done     <= 1'b1;
        noDevice <= 1'b0;
        if (crcNow == 8'h00) begin
          tempOk  <= 1'b1;
          tempErr <= 1'b0;
          tempRaw <= {tByte[1], tByte[0]};
        end else begin
          tempOk  <= 1'b0;
          tempErr <= 1'b1;
        end
      end
    end
  end

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (tempOk != tempErr));

  // R9
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tempRaw) |-> (done && tempOk));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/therm_seq.sv
`timescale 1ns/1ps
module therm_seq
  import therm_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned CONV_MS = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        opReq,
  output logic [1:0]  opKind,
  output logic [7:0]  opData,
  input  logic        opDone,
  input  logic [7:0]  opRdData,
  input  logic        opPresence,
  output logic        busy,
  output logic        done,
  output logic        tempOk,
  output logic        tempErr,
  output logic        noDevice,
  output logic [15:0] tempRaw
);

  dpStrobe_t strb;

  therm_seq_ctrl #(.CLK_HZ(CLK_HZ), .CONV_MS(CONV_MS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opDone(opDone),
    .opPresence(opPresence), .opReq(opReq), .opKind(opKind),
    .opData(opData), .busy(busy), .strb(strb)
  );

  therm_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(opRdData),
    .tempRaw(tempRaw), .tempOk(tempOk), .tempErr(tempErr),
    .noDevice(noDevice), .done(done)
  );

endmodule

// File: tb/therm_seq_tb_top.sv
`timescale 1ns/1ps
module therm_seq_tb_top;

  localparam int CLK_HZ  = 1000;
  localparam int CONV_MS = 1000;
  localparam int DLY     = (CLK_HZ / 1000) * CONV_MS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opReq;
  logic [1:0] opKind;
  logic [7:0] opData;
  logic opDone = 1'b0;
  logic [7:0] opRdData = 8'h00;
  logic opPresence = 1'b0;
  logic busy, done, tempOk, tempErr, noDevice;
  logic [15:0] tempRaw;

  always #2 clk = ~clk;

  therm_seq #(.CLK_HZ(CLK_HZ), .CONV_MS(CONV_MS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opReq(opReq), .opKind(opKind),
    .opData(opData), .opDone(opDone), .opRdData(opRdData),
    .opPresence(opPresence), .busy(busy), .done(done), .tempOk(tempOk),
    .tempErr(tempErr), .noDevice(noDevice), .tempRaw(tempRaw)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  logic [7:0] spad [9];
  bit pres1, pres2;
  int rstSeen, rdSeen;
  logic [15:0] lastGood = 16'h0000;

  logic [9:0]  expOps [$];
  logic [18:0] expRes [$];
  string       expTag [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic x;
    r = c;
    for (int b = 0; b < 8; b++) begin
      x = r[0] ^ d[b];
      r = {1'b0, r[7:1]};
      if (x) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  // bus master model
  initial begin
    logic [1:0] k;
    forever begin
      @(negedge clk);
      if (opReq) begin
        k = opKind;
        repeat (3) @(posedge clk);
        #1;
        opDone = 1'b1;
        opRdData = 8'h00;
        opPresence = 1'b0;
        if (k == 2'd0) begin
          opPresence = (rstSeen == 0) ? pres1 : pres2;
          rstSeen++;
        end else if (k == 2'd2) begin
          if (rdSeen < 9) opRdData = spad[rdSeen];
          rdSeen++;
        end
        @(posedge clk);
        #1 opDone = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit lastWasConv = 0;
    bit convPend = 0;
    int convCyc = 0;
    bit outstanding = 0;
    bit prevReq = 0;
    logic [9:0] e;
    logic [18:0] r;
    string t;
    forever begin
      @(negedge clk);
      cyc++;
      if (opDone) begin
        outstanding = 0;
        if (lastWasConv) begin
          convPend = 1;
          convCyc = cyc;
          lastWasConv = 0;
        end
      end
      if (opReq) begin
        check(!prevReq && !outstanding, "R5", "request overlaps previous", 32'(prevReq), 0);
        outstanding = 1;
        if (convPend) begin
          check(cyc - convCyc == DLY + 1, "R4", "reset delay after convert",
                32'(cyc - convCyc), 32'(DLY + 1));
          convPend = 0;
        end
        if (expOps.size() == 0) begin
          check(0, "R3", "unexpected request", {22'd0, opKind, opData}, 0);
        end else begin
          e = expOps.pop_front();
          check(opKind == e[9:8] && (opKind != 2'd1 || opData == e[7:0]), "R3",
                "request kind/data", {22'd0, opKind, opData}, {22'd0, e});
        end
        lastWasConv = (opKind == 2'd1 && opData == 8'h44);
      end
      prevReq = opReq;
      if (done) begin
        if (expRes.size() == 0) begin
          check(0, "R11", "unexpected done", 1, 0);
        end else begin
          r = expRes.pop_front();
          t = expTag.pop_front();
          check({tempOk, tempErr, noDevice, tempRaw} == r, t, "result {ok,err,nodev,raw}",
                {13'd0, tempOk, tempErr, noDevice, tempRaw}, {13'd0, r});
        end
      end
    end
  end

  task automatic runMeas(input logic [15:0] raw, input bit goodCrc, input bit p1,
                         input bit p2, input bit extraStart, input string tag);
    logic [7:0] c;
    logic [18:0] held;
    spad[0] = raw[7:0];
    spad[1] = raw[15:8];
    spad[2] = 8'h4B; spad[3] = 8'h46; spad[4] = 8'h7F;
    spad[5] = 8'hFF; spad[6] = 8'h0C; spad[7] = 8'h10;
    c = 8'h00;
    for (int i = 0; i < 8; i++) c = refCrc(c, spad[i]);
    spad[8] = goodCrc ? c : (c ^ 8'h5A);
    rstSeen = 0;
    rdSeen = 0;
    pres1 = p1;
    pres2 = p2;
    expOps.push_back({2'd0, 8'h00});
    if (p1) begin
      expOps.push_back({2'd1, 8'hCC});
      expOps.push_back({2'd1, 8'h44});
      expOps.push_back({2'd0, 8'h00});
      if (p2) begin
        expOps.push_back({2'd1, 8'hCC});
        expOps.push_back({2'd1, 8'hBE});
        for (int i = 0; i < 9; i++) expOps.push_back({2'd2, 8'h00});
      end
    end
    if (!p1 || !p2) held = {3'b011, lastGood};
    else if (goodCrc) begin
      held = {3'b100, raw};
      lastGood = raw;
    end else held = {3'b010, lastGood};
    expRes.push_back(held);
    expTag.push_back(tag);

    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    if (extraStart) begin
      repeat (40) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R11", "done lasts one cycle", 32'(done), 0);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R2", "idle after completion", 32'(busy), 0);
    check({tempOk, tempErr, noDevice, tempRaw} == held, "R9", "outputs held after completion",
          {13'd0, tempOk, tempErr, noDevice, tempRaw}, {13'd0, held});
    check(expOps.size() == 0 && expRes.size() == 0, tag, "pending expectations",
          32'(expOps.size()), 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({busy, done, tempOk, tempErr, noDevice, opReq} == 6'b0 && tempRaw == 16'h0, "R1",
          "reset state", {10'd0, busy, done, tempOk, tempErr, noDevice, opReq, tempRaw}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(opReq == 1'b0 && busy == 1'b0, "R1", "idle without start", 32'(busy), 0);

    runMeas(16'h0191, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    runMeas(16'hFF5E, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    runMeas(16'h0550, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    runMeas(16'h0022, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    runMeas(16'h0033, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    runMeas(16'h07D0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule